// File: doc/BRIEF.md
# Compare-Driven Interval Timer Channel

This block is one interval timer channel driven through a small word-addressed register port. An up-counter advances on ticks taken from a free-running internal divider, a slow tick input, or the rising edges of an external chained input. Two compare registers watch the count. The lower one ("A") and the upper one ("C") each raise a status flag when they match, and each can set, clear or toggle a waveform pin. The counter runs in one of two ways. In the first it runs freely and wraps at its full width. In the second it restarts from zero on a C match, and it can also switch its own clock off on that match, which gives a one-shot timer.

Software starts the timer by writing the start and restart bits to the control register together. It then either polls the status word or unmasks flags onto the interrupt output. A read of the status word clears its event flags.

Top module: `tc_channel`

## Requirements
- R1: After reset the count, both compare registers, the mode word, the event flags, the interrupt mask, the waveform pin and the interrupt output are all 0, and the counter clock is stopped.
- R2: Mode bits [2:0] pick the tick source: 0, 1, 2 and 3 give one tick every 2, 8, 32 and 128 cycles of an internal divider that counts from reset; 4 takes `slow_tick` sampled each cycle; 5 takes each rising edge of `ext_in`; 6 and 7 give no ticks. The count advances only on a tick while the counter clock is on.
- R3: Control word (address 0) bit0 switches the counter clock on, bit1 switches it off and wins over bit0, and bit2 forces the count to 0. Status bit8 shows whether the clock is on. While the clock is off the count holds.
- R4: With mode bit3 clear the count runs from 2^CNT_W-1 to 0, sets status bit0 (overflow) and is not reset by a C match.
- R5: With mode bit3 set, a tick that finds the count equal to C reloads 0 and sets status bit2.
- R6: With mode bit4 set, a C match switches the counter clock off, unless the same cycle writes a control word with bit0 set.
- R7: A tick that finds the count equal to A sets status bit1.
- R8: Mode bits [6:5] (A match) and [8:7] (C match) act on `tioa` with the encoding 0 none, 1 set, 2 clear, 3 toggle.
- R9: A read of the status word (address 5) returns the flags held before the read and then clears them. An event in the same cycle as the read is kept.
- R10: A write to address 6 sets mask bits and a write to address 7 clears them (0xFF clears all). Address 8 reads the mask. `irq` is high when any flag bit [2:0] has its mask bit set.
- R11: A control word with bit2 that lands on the same tick as a C match in restart mode gives a single return to 0, and status bit2 is set.
- R12: When A and C match on the same tick and the C action is not "none", the C action decides `tioa`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronised on release |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (needed for the status clear) |
| addr | input | 4 | Word address: 0 ctrl, 1 mode, 2 A, 3 C, 4 count, 5 status, 6 mask set, 7 mask clear, 8 mask |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from the addressed register |
| slow_tick | input | 1 | Slow clock tick, one cycle high per tick |
| ext_in | input | 1 | External chained clock level, synchronous to clk |
| tioa | output | 1 | Waveform pin |
| irq | output | 1 | Masked flag interrupt |

## Verification
The assertions take it that `ext_in` and `slow_tick` are already synchronous to `clk` and that `wr_en` and `rd_en` never strike in the same cycle. The bench drives every input at the falling edge from one task at a time, so a write and a read never overlap. The properties about flag clearing assume that no counting tick lands in the cycle of the status read. Because of that, the status words that the bench checks against fixed values are read only after the clock has been switched off or the one-shot has stopped.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int unsigned REG_AW = 4;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned NFLAG  = 3;
  localparam int unsigned FLAG_OVF = 0;
  localparam int unsigned FLAG_RA  = 1;
  localparam int unsigned FLAG_RC  = 2;

  typedef enum logic [REG_AW-1:0] {
    A_CTRL  = 4'd0,
    A_MODE  = 4'd1,
    A_CMPA  = 4'd2,
    A_CMPC  = 4'd3,
    A_COUNT = 4'd4,
    A_STAT  = 4'd5,
    A_MSET  = 4'd6,
    A_MCLR  = 4'd7,
    A_MASK  = 4'd8
  } reg_addr_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_TOG  = 2'd3
  } pin_act_e;

  typedef struct packed {
    pin_act_e   c_act;
    pin_act_e   a_act;
    logic       stop_c;
    logic       auto_rst;
    logic [2:0] clk_sel;
  } mode_t;

  localparam int unsigned MODE_W = $bits(mode_t);
endpackage

// File: rtl/tc_tick_sel.sv
module tc_tick_sel (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       slow_tick,
  input  logic       ext_in,
  output logic       tick
);
  localparam int unsigned NUM_TAPS = 4;
  localparam int unsigned PRESC_W  = 2 * NUM_TAPS - 1;

  logic [PRESC_W-1:0]  presc_q, presc_d;
  logic                ext_q;
  logic [NUM_TAPS-1:0] tap;

  generate
    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
      assign tap[g] = &presc_q[2*g:0];
    end
  endgenerate

  always_comb begin
    presc_d = presc_q + PRESC_W'(1);
    unique case (sel)
      3'd0, 3'd1, 3'd2, 3'd3: tick = tap[sel[1:0]];
      3'd4:                   tick = slow_tick;
      3'd5:                   tick = ext_in & ~ext_q;
      default:                tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      ext_q   <= 1'b0;
    end else begin
      presc_q <= presc_d;
      ext_q   <= ext_in;
    end
  end
endmodule

// File: rtl/tc_count_core.sv
module tc_count_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             go_on,
  input  logic             go_off,
  input  logic             restart,
  input  logic             auto_rst,
  input  logic             stop_c,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_c,
  output logic [CNT_W-1:0] cnt_q,
  output logic             run_q,
  output logic             tick_act,
  output logic             a_ev,
  output logic             c_ev,
  output logic             ovf_ev
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_d;
  logic             run_d;
  logic             at_c;

  always_comb begin
    tick_act = tick & run_q;
    at_c     = (cnt_q == cmp_c);
    a_ev     = tick_act & (cnt_q == cmp_a);
    c_ev     = tick_act & at_c;
    ovf_ev   = tick_act & (cnt_q == CNT_MAX) & ~(auto_rst & at_c);

    cnt_d = cnt_q;
    if (restart)
      cnt_d = '0;
    else if (tick_act)
      cnt_d = (auto_rst && at_c) ? '0 : cnt_q + CNT_W'(1);

    run_d = run_q;
    if (go_off)
      run_d = 1'b0;
    else if (go_on)
      run_d = 1'b1;
    else if (c_ev && stop_c)
      run_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end
endmodule

// File: rtl/tc_wave.sv
module tc_wave
  import tc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     a_ev,
  input  logic     c_ev,
  input  pin_act_e a_act,
  input  pin_act_e c_act,
  output logic     pin_q
);
  logic     pin_d;
  pin_act_e act;
  logic     fire;

  function automatic logic apply_act(input pin_act_e a, input logic cur);
    unique case (a)
      ACT_SET: apply_act = 1'b1;
      ACT_CLR: apply_act = 1'b0;
      ACT_TOG: apply_act = ~cur;
      default: apply_act = cur;
    endcase
  endfunction

  always_comb begin
    fire = 1'b1;
    act  = ACT_NONE;
    if (c_ev && c_act != ACT_NONE)
      act = c_act;
    else if (a_ev)
      act = a_act;
    else
      fire = 1'b0;
    pin_d = fire ? apply_act(act, pin_q) : pin_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end
endmodule

// File: rtl/tc_channel.sv
module tc_channel
  import tc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic              slow_tick,
  input  logic              ext_in,
  output logic              tioa,
  output logic              irq
);
  mode_t            mode_q, mode_d;
  logic [CNT_W-1:0] cmp_a_q, cmp_a_d, cmp_c_q, cmp_c_d;
  logic [NFLAG-1:0] flags_q, flags_d, mask_q, mask_d, ev_vec;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, tick, tick_act, a_ev, c_ev, ovf_ev;
  logic             ctrl_wr, st_rd;
  logic             unused_wdata;

  assign unused_wdata = ^wdata[BUS_W-1:MODE_W];
  assign ctrl_wr = wr_en && (addr == A_CTRL);
  assign st_rd   = rd_en && (addr == A_STAT);

  tc_tick_sel u_tick (
    .clk(clk), .rst_n(rst_n), .sel(mode_q.clk_sel),
    .slow_tick(slow_tick), .ext_in(ext_in), .tick(tick)
  );

  tc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .go_on(ctrl_wr & wdata[0]), .go_off(ctrl_wr & wdata[1]),
    .restart(ctrl_wr & wdata[2]), .auto_rst(mode_q.auto_rst),
    .stop_c(mode_q.stop_c), .cmp_a(cmp_a_q), .cmp_c(cmp_c_q),
    .cnt_q(cnt_q), .run_q(run_q), .tick_act(tick_act),
    .a_ev(a_ev), .c_ev(c_ev), .ovf_ev(ovf_ev)
  );

  tc_wave u_wave (
    .clk(clk), .rst_n(rst_n), .a_ev(a_ev), .c_ev(c_ev),
    .a_act(mode_q.a_act), .c_act(mode_q.c_act), .pin_q(tioa)
  );

  always_comb begin
    ev_vec = '0;
    ev_vec[FLAG_OVF] = ovf_ev;
    ev_vec[FLAG_RA]  = a_ev;
    ev_vec[FLAG_RC]  = c_ev;

    mode_d  = mode_q;
    cmp_a_d = cmp_a_q;
    cmp_c_d = cmp_c_q;
    mask_d  = mask_q;
    if (wr_en) begin
      unique case (addr)
        A_MODE:  mode_d  = mode_t'(wdata[MODE_W-1:0]);
        A_CMPA:  cmp_a_d = wdata[CNT_W-1:0];
        A_CMPC:  cmp_c_d = wdata[CNT_W-1:0];
        A_MSET:  mask_d  = mask_q | wdata[NFLAG-1:0];
        A_MCLR:  mask_d  = mask_q & ~wdata[NFLAG-1:0];
        default: ;
      endcase
    end
    flags_d = (st_rd ? '0 : flags_q) | ev_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      cmp_a_q <= '0;
      cmp_c_q <= '0;
      mask_q  <= '0;
      flags_q <= '0;
    end else begin
      mode_q  <= mode_d;
      cmp_a_q <= cmp_a_d;
      cmp_c_q <= cmp_c_d;
      mask_q  <= mask_d;
      flags_q <= flags_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_MODE:  rdata = BUS_W'(mode_q);
      A_CMPA:  rdata = BUS_W'(cmp_a_q);
      A_CMPC:  rdata = BUS_W'(cmp_c_q);
      A_COUNT: rdata = BUS_W'(cnt_q);
      A_STAT:  rdata = BUS_W'({tioa, run_q, 5'b0, flags_q});
      A_MASK:  rdata = BUS_W'(mask_q);
      default: rdata = '0;
    endcase
  end

  assign irq = |(flags_q & mask_q);
endmodule

// File: rtl/tc_channel_chk.sv
module tc_channel_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             tioa,
  input logic             tick_act,
  input logic [CNT_W-1:0] cnt_q,
  input logic             c_ev,
  input logic             auto_rst,
  input logic             stop_c,
  input logic             ctrl_wr,
  input logic [2:0]       ctrl_bits,
  input logic             run_q,
  input logic [2:0]       flags_q,
  input logic [2:0]       mask_q,
  input logic             st_rd
);
  localparam logic [CNT_W-1:0] TOP = '1;

  // R1
  reset_state_chk: assert property (@(posedge clk) $rose(rst_n) |-> (cnt_q == '0 && !run_q && !tioa && flags_q == '0));

  // R3
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_bits[2]) |=> (cnt_q == '0));

  // R3
  off_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_bits[1]) |=> !run_q);

  // R4
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_act && !auto_rst && cnt_q == TOP && !(ctrl_wr && ctrl_bits[2])) |=> (cnt_q == '0 && flags_q[0]));

  // R5
  auto_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_ev && auto_rst) |=> (cnt_q == '0 && flags_q[2]));

  // R6
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_ev && stop_c && !(ctrl_wr && ctrl_bits[0])) |=> !run_q);

  // R9
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rd && !tick_act) |=> (flags_q == '0));

  // R10
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
endmodule

bind tc_channel tc_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .tioa(tioa), .tick_act(tick_act),
  .cnt_q(cnt_q), .c_ev(c_ev), .auto_rst(mode_q.auto_rst), .stop_c(mode_q.stop_c),
  .ctrl_wr(ctrl_wr), .ctrl_bits(wdata[2:0]), .run_q(run_q),
  .flags_q(flags_q), .mask_q(mask_q), .st_rd(st_rd)
);

// File: tb/tc_channel_tb.sv
module tc_channel_tb;
  localparam int W    = 10;
  localparam int MAXV = (1 << W) - 1;

  logic        clk, rst_n, wr_en, rd_en, slow_tick, ext_in;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata;
  logic        tioa, irq;

  int n_chk, n_fail;
  bit done, live;

  tc_channel #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .slow_tick(slow_tick), .ext_in(ext_in),
    .tioa(tioa), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // behavioural reference
  int m_presc, m_cnt, m_en, m_flags, m_mask, m_tioa, m_mode, m_a, m_c;
  bit m_ext;

  function automatic int pin_apply(int act, int cur);
    if (act == 1) return 1;
    if (act == 2) return 0;
    if (act == 3) return 1 - cur;
    return cur;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_presc = 0; m_cnt = 0; m_en = 0; m_flags = 0; m_mask = 0;
      m_tioa = 0; m_mode = 0; m_a = 0; m_c = 0; m_ext = 0;
    end else begin
      int sel, div, ev, nxt_cnt, nxt_en;
      bit tk, act, ha, hc, ov, autom;
      sel = m_mode % 8;
      autom = ((m_mode >> 3) % 2) == 1;
      tk = 0;
      if (sel < 4) begin
        div = 2 << (2 * sel);
        tk = (m_presc % div) == div - 1;
      end else if (sel == 4) tk = slow_tick;
      else if (sel == 5) tk = ext_in && !m_ext;
      act = tk && (m_en == 1);
      ha = act && m_cnt == m_a;
      hc = act && m_cnt == m_c;
      ov = act && m_cnt == MAXV && !(autom && m_cnt == m_c);
      nxt_cnt = m_cnt;
      if (wr_en && addr == 0 && wdata[2]) nxt_cnt = 0;
      else if (act) nxt_cnt = (autom && m_cnt == m_c) ? 0 : (m_cnt + 1) % (MAXV + 1);
      nxt_en = m_en;
      if (wr_en && addr == 0 && wdata[1]) nxt_en = 0;
      else if (wr_en && addr == 0 && wdata[0]) nxt_en = 1;
      else if (hc && ((m_mode >> 4) % 2) == 1) nxt_en = 0;
      if (hc && (m_mode >> 7) % 4 != 0) m_tioa = pin_apply((m_mode >> 7) % 4, m_tioa);
      else if (ha) m_tioa = pin_apply((m_mode >> 5) % 4, m_tioa);
      ev = (ov ? 1 : 0) + (ha ? 2 : 0) + (hc ? 4 : 0);
      m_flags = ((rd_en && addr == 5) ? 0 : m_flags) | ev;
      if (wr_en) begin
        if (addr == 1) m_mode = int'(wdata[8:0]);
        if (addr == 2) m_a = int'(wdata[W-1:0]);
        if (addr == 3) m_c = int'(wdata[W-1:0]);
        if (addr == 6) m_mask = m_mask | int'(wdata[2:0]);
        if (addr == 7) m_mask = m_mask & ~int'(wdata[2:0]);
      end
      m_cnt = nxt_cnt;
      m_en = nxt_en;
      m_presc = (m_presc + 1) % 128;
      m_ext = ext_in;
    end
  end

  function automatic int exp_rd(int a);
    case (a)
      1: return m_mode;
      2: return m_a;
      3: return m_c;
      4: return m_cnt;
      5: return m_flags + (m_en << 8) + (m_tioa << 9);
      8: return m_mask;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison of the pins
  always @(negedge clk) begin
    if (live) begin
      chk("R8 tioa", int'(tioa), m_tioa);
      chk("R10 irq", int'(irq), ((m_flags & m_mask) != 0) ? 1 : 0);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'(a); wdata = 32'(d);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input string req, output int v);
    @(negedge clk);
    rd_en = 1'b1; addr = 4'(a);
    #1;
    v = int'(rdata);
    chk(req, v, exp_rd(a));
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  // pat 0: slow tick every 5th cycle, ext toggles every 3rd; pat 1: slow tick constant
  int cyc;
  task automatic idle(input int n, input int pat);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      slow_tick = (pat == 1) ? 1'b1 : ((cyc % 5) == 0);
      if (pat == 0 && (cyc % 3) == 0) ext_in = ~ext_in;
    end
  endtask

  function automatic int mk_mode(int sel, int au, int st, int aa, int ca);
    return sel + (au << 3) + (st << 4) + (aa << 5) + (ca << 7);
  endfunction

  initial begin
    int v, v2;
    n_chk = 0; n_fail = 0; done = 0; live = 0; cyc = 0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    slow_tick = 1'b0; ext_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    live = 1;

    // R1 reset state
    for (int a = 1; a <= 8; a++) begin
      rd(a, "R1 reset value", v);
      chk("R1 reset literal", v, 0);
    end

    // R10 mask set/clear
    wr(6, 7);      rd(8, "R10 mask", v); chk("R10 mask set", v, 7);
    wr(7, 'hFF);   rd(8, "R10 mask", v); chk("R10 mask clear all", v, 0);
    wr(6, 4);      rd(8, "R10 mask", v); chk("R10 mask C only", v, 4);

    // R2 each tick source, R3 start with restart
    wr(3, 700); wr(2, 600);
    for (int s = 0; s < 8; s++) begin
      wr(1, mk_mode(s, 0, 0, 0, 0));
      wr(0, 5);
      idle(300, 0);
      rd(4, "R2 count per source", v);
      if (s >= 6) chk("R2 no tick source", v, 0);
    end

    // R3 clock off holds count
    wr(1, mk_mode(1, 0, 0, 0, 0)); wr(0, 5); idle(40, 0);
    wr(0, 2);
    rd(4, "R3 count", v); idle(30, 0); rd(4, "R3 count", v2);
    chk("R3 held while off", v2, v);
    rd(5, "R3 status", v); chk("R3 run bit off", (v >> 8) & 1, 0);
    wr(0, 3);
    rd(5, "R3 status", v); chk("R3 off wins over on", (v >> 8) & 1, 0);

    // R5 R7 R8 restart mode with pin set on A, clear on C
    wr(6, 7);
    wr(1, mk_mode(4, 1, 0, 1, 2)); wr(3, 6); wr(2, 2);
    wr(0, 5); idle(50, 1);
    rd(4, "R5 count bounded", v);
    chk("R5 count at most C", (v <= 6) ? 1 : 0, 1);
    wr(0, 2);
    rd(5, "R9 status first read", v);
    chk("R5 C flag", (v >> 2) & 1, 1);
    chk("R7 A flag", (v >> 1) & 1, 1);
    rd(5, "R9 status after clear", v);
    chk("R9 flags cleared", v & 7, 0);

    // R8 toggle on both compares
    wr(1, mk_mode(4, 1, 0, 3, 3)); wr(0, 5); idle(45, 0); wr(0, 2);
    rd(5, "R8 toggle status", v);

    // R6 one-shot
    wr(1, mk_mode(4, 1, 1, 0, 1)); wr(3, 10); wr(0, 5); idle(40, 1);
    rd(5, "R6 status", v);
    chk("R6 clock stopped", (v >> 8) & 1, 0);
    chk("R6 C flag", (v >> 2) & 1, 1);
    chk("R6 pin set on C", (v >> 9) & 1, 1);
    rd(4, "R6 count", v); chk("R6 count reloaded", v, 0);

    // R4 free-running wrap past C
    wr(1, mk_mode(4, 0, 0, 0, 0)); wr(3, 5); wr(0, 5);
    idle(MAXV + 20, 1); wr(0, 2);
    rd(4, "R4 count", v); chk("R4 count passed C", (v > 5) ? 1 : 0, 1);
    rd(5, "R4 status", v); chk("R4 overflow flag", v & 1, 1);

    // R11 restart on the same tick as a C match
    wr(1, mk_mode(4, 1, 0, 0, 0)); wr(3, 4); wr(0, 5);
    rd(5, "R11 clear flags", v);
    begin
      int k;
      k = 0;
      slow_tick = 1'b1;
      @(negedge clk);
      while (m_cnt != 4 && k < 50) begin @(negedge clk); k++; end
      wr_en = 1'b1; addr = 4'd0; wdata = 32'd4;
      @(posedge clk); #1; wr_en = 1'b0;
      slow_tick = 1'b0;
    end
    rd(4, "R11 count", v); chk("R11 single reset", v, 0);
    wr(0, 2);
    rd(5, "R11 status", v); chk("R11 C flag", (v >> 2) & 1, 1);

    // R12 A and C equal: C action wins
    wr(1, mk_mode(4, 1, 0, 1, 2)); wr(2, 3); wr(3, 3);
    wr(0, 5); idle(40, 1); wr(0, 2);
    rd(5, "R12 status", v); chk("R12 C action wins", (v >> 9) & 1, 0);

    done = 1;
    live = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule